// File: doc/BRIEF.md
# Tagged Transmit Byte Queue with Held Status

This block is the byte queue between a processor write port and the serial transmit side of a link controller. The processor writes one byte per strobe. When software wants to mark the final byte of a packet, it first raises a one-cycle request that arms a sticky end-of-packet flag. That flag is copied into the tag of the next byte accepted into the queue, and is then dropped again. The serializer pops bytes from the queue one at a time. Each pop is paced by a bit-clock enable, and it receives the byte together with its tag.

The processor sees a two-bit occupancy level and a sticky overflow flag. After any access from either side, the level output is frozen. It stays frozen until two bit-clock enable pulses have passed. The freeze stops the level from changing underneath a processor whose bus cycles are much shorter than a bit period.

Both ports are plain strobes rather than valid/ready handshakes. A write attempted while the queue is full must be dropped and reported, so there is no back-pressure on the write side: software is expected to watch the level before it writes. On the read side, the serializer decides when to pop, and an empty queue simply refuses the pop.

Top module: `txq_tagged_fifo`

## Requirements
- R1: After reset, `fifo_level` is 00, `overflow` is 0, `eop_armed` is 0, and `rd_byte` and `rd_last` are 0.
- R2: The queue holds up to 19 bytes. Bytes leave in the same order they were written, each with the tag it was written with.
- R3: A write while 19 bytes are stored is dropped and leaves the contents unchanged. It sets `overflow`, which stays at 1 until reset.
- R4: A pulse on `eop_req` sets `eop_armed` from the next cycle on. The next accepted write stores tag 1 and clears `eop_armed`. If `eop_req` and an accepted write fall in the same cycle, the byte takes the old flag value and `eop_armed` ends at 1.
- R5: A pop request on an empty queue leaves `rd_byte` and `rd_last` unchanged and moves no pointer.
- R6: A pop occurs only in a cycle where `rd_en` and `bit_tick` are both 1 and the queue is not empty. `rd_byte` and `rd_last` show the popped entry from the following cycle.
- R7: When settled, `fifo_level` encodes the stored count n as follows: 00 for n=0, 01 for 1 to 3, 10 for 4 to 18, and 11 for 19.
- R8: An access is a write strobe, or a pop request with `bit_tick` high. After an access, `fifo_level` keeps its value through the second later `bit_tick` cycle, and takes the new level in the cycle after that. Cycles without `bit_tick` do not shorten the hold.
- R9: A write and a pop in the same cycle are judged against the count at the start of that cycle. At 19 the write is dropped and the pop proceeds. At 0 the write is stored and the pop is refused. In between, both take effect and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable per serial bit period |
| wr_en | input | 1 | Processor write strobe |
| wr_byte | input | 8 | Byte to store |
| eop_req | input | 1 | Arms the end-of-packet flag for the next stored byte |
| eop_armed | output | 1 | Current state of the end-of-packet flag |
| rd_en | input | 1 | Serializer pop request, honoured on a `bit_tick` cycle |
| rd_byte | output | 8 | Last popped byte |
| rd_last | output | 1 | Tag of the last popped byte |
| fifo_level | output | 2 | Held occupancy level |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Writes and pops can land in the same cycle. The bench provokes this three times: at full, where the write is lost and the oldest byte still leaves; at empty, where the byte is stored but the pop is refused; and at a middle depth. Each case is judged by reading out the whole queue and comparing it against an arithmetic expectation. Arming the end-of-packet flag in the same cycle as a write is a second such collision. The bench judges it by the tags that come out of the queue.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LVL_EMPTY = 2'b00,
    LVL_LOW   = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_FULL  = 2'b11
  } txq_level_e;

  typedef struct packed {
    logic              last;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DEPTH = 19,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  txq_entry_t    din,
  output txq_entry_t    head,
  output logic [CW-1:0] count
);
  txq_entry_t    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/txq_level_map.sv
module txq_level_map
  import txq_pkg::*;
#(
  parameter int DEPTH  = 19,
  parameter int THRESH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  output txq_level_e    level
);
  always_comb begin
    if (count == '0)                   level = LVL_EMPTY;
    else if (count < CW'(THRESH))      level = LVL_LOW;
    else if (count < CW'(DEPTH))       level = LVL_HIGH;
    else                               level = LVL_FULL;
  end
endmodule

// File: rtl/txq_status_hold.sv
module txq_status_hold
  import txq_pkg::*;
#(
  parameter int HOLD_BITS = 2,
  localparam int HW = $clog2(HOLD_BITS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       access,
  input  txq_level_e live,
  output txq_level_e held
);
  logic [HW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      held   <= LVL_EMPTY;
    end else begin
      if (access)                     remain <= HW'(HOLD_BITS);
      else if (bit_tick && remain != '0) remain <= remain - 1'b1;
      if (!access && remain == '0)    held <= live;
    end
  end
endmodule

// File: rtl/txq_tagged_fifo.sv
module txq_tagged_fifo
  import txq_pkg::*;
#(
  parameter int DEPTH     = 19,
  parameter int THRESH    = 4,
  parameter int HOLD_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              eop_req,
  output logic              eop_armed,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_last,
  output logic [1:0]        fifo_level,
  output logic              overflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          full, empty, push, pop, access;
  txq_entry_t    head, din;
  txq_level_e    live, held;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign push   = wr_en && !full;
  assign pop    = rd_en && bit_tick && !empty;
  assign access = wr_en || (rd_en && bit_tick);
  assign din    = '{last: eop_armed, data: wr_byte};

  txq_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(din), .head(head), .count(count)
  );

  txq_level_map #(.DEPTH(DEPTH), .THRESH(THRESH)) i_map (
    .count(count), .level(live)
  );

  txq_status_hold #(.HOLD_BITS(HOLD_BITS)) i_hold (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .access(access), .live(live), .held(held)
  );

  assign fifo_level = held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_armed <= 1'b0;
      overflow  <= 1'b0;
      rd_byte   <= '0;
      rd_last   <= 1'b0;
    end else begin
      if (eop_req)      eop_armed <= 1'b1;
      else if (push)    eop_armed <= 1'b0;
      if (wr_en && full) overflow <= 1'b1;
      if (pop) begin
        rd_byte <= head.data;
        rd_last <= head.last;
      end
    end
  end
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int DEPTH = 19,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          wr_en,
  input logic          rd_en,
  input logic          eop_req,
  input logic          push,
  input logic [CW-1:0] count,
  input logic          eop_armed,
  input logic          overflow,
  input logic [1:0]    fifo_level,
  input logic [7:0]    rd_byte,
  input logic          rd_last
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_sticky_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_full_write_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && count == CW'(DEPTH)) |=> overflow);

  assert_eop_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eop_req |=> eop_armed);

  assert_eop_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !eop_req) |=> !eop_armed);

  assert_empty_pop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bit_tick && count == '0) |=> $stable({rd_byte, rd_last}));

  assert_no_tick_no_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !wr_en) |=> $stable(count));

  assert_level_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || (rd_en && bit_tick)) |=> $stable(fifo_level));
endmodule

bind txq_tagged_fifo txq_checker #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
  .rd_en(rd_en), .eop_req(eop_req), .push(push), .count(count),
  .eop_armed(eop_armed), .overflow(overflow), .fifo_level(fifo_level),
  .rd_byte(rd_byte), .rd_last(rd_last)
);

// File: tb/test_txq_tagged_fifo.sv
module test_txq_tagged_fifo;
  localparam int DEPTH = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, wr_en = 1'b0, eop_req = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       eop_armed, rd_last, overflow;
  logic [7:0] rd_byte;
  logic [1:0] fifo_level;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  txq_tagged_fifo i_txq_tagged_fifo (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_byte(wr_byte), .eop_req(eop_req), .eop_armed(eop_armed),
    .rd_en(rd_en), .rd_byte(rd_byte), .rd_last(rd_last),
    .fifo_level(fifo_level), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lvl(input int n);
    if (n == 0) return 0;
    if (n < 4) return 1;
    if (n < DEPTH) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] pat(input int n, input int k);
    return 8'((n * 13 + k * 7 + 1) & 255);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; bit_tick = 0; eop_req = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] b);
    wr_en = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_arm();
    eop_req = 1'b1;
    @(negedge clk);
    eop_req = 1'b0;
  endtask

  task automatic do_pop();
    rd_en = 1'b1; bit_tick = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic settle();
    bit_tick = 1'b1;
    repeat (3) @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(fifo_level == 2'b00, "R1 level", fifo_level, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    chk(eop_armed == 1'b0, "R1 eop_armed", eop_armed, 0);
    chk({rd_last, rd_byte} == 9'h0, "R1 read regs", {rd_last, rd_byte}, 0);

    // R2 R7 sweep over every occupancy, last byte tagged
    for (int n = 0; n <= DEPTH; n++) begin
      do_reset();
      for (int k = 0; k < n; k++) begin
        if (k == n - 1) do_arm();
        do_write(pat(n, k));
      end
      settle();
      chk(fifo_level == 2'(lvl(n)), "R7 level at count", fifo_level, lvl(n));
      for (int k = 0; k < n; k++) begin
        do_pop();
        chk(rd_byte == pat(n, k), "R2 order", rd_byte, pat(n, k));
        chk(rd_last == (k == n - 1), "R2 tag", rd_last, (k == n - 1));
      end
      settle();
      chk(fifo_level == 2'b00, "R7 drained level", fifo_level, 0);
    end

    // R3 overflow: write past full, then read out
    do_reset();
    for (int k = 0; k < DEPTH; k++) do_write(pat(50, k));
    chk(overflow == 1'b0, "R3 no overflow at full", overflow, 0);
    do_write(8'hEE);
    chk(overflow == 1'b1, "R3 overflow set", overflow, 1);
    for (int k = 0; k < DEPTH; k++) begin
      do_pop();
      chk(rd_byte == pat(50, k), "R3 contents kept", rd_byte, pat(50, k));
    end
    // R5 pop on empty leaves outputs unchanged
    do_pop();
    chk(rd_byte == pat(50, DEPTH - 1), "R5 empty pop data", rd_byte, pat(50, DEPTH - 1));
    settle();
    chk(fifo_level == 2'b00, "R5 still empty", fifo_level, 0);
    chk(overflow == 1'b1, "R3 overflow sticky", overflow, 1);
    do_write(8'h5A);
    do_pop();
    chk(rd_byte == 8'h5A, "R5 pointers unmoved", rd_byte, 8'h5A);

    // R4 end-of-packet flag
    do_reset();
    do_arm();
    chk(eop_armed == 1'b1, "R4 armed", eop_armed, 1);
    do_write(8'hA1);
    chk(eop_armed == 1'b0, "R4 cleared by write", eop_armed, 0);
    do_write(8'hA2);
    eop_req = 1'b1;
    do_write(8'hA3);
    eop_req = 1'b0;
    chk(eop_armed == 1'b1, "R4 same-cycle arm kept", eop_armed, 1);
    do_write(8'hA4);
    chk(eop_armed == 1'b0, "R4 cleared again", eop_armed, 0);
    for (int k = 0; k < 4; k++) begin
      do_pop();
      chk(rd_byte == 8'(8'hA1 + k), "R4 data", rd_byte, 8'hA1 + k);
      chk(rd_last == (k == 0 || k == 3), "R4 tag", rd_last, (k == 0 || k == 3));
    end

    // R6 pop needs bit_tick
    do_reset();
    do_write(8'h11);
    do_write(8'h22);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    chk(rd_byte == 8'h00, "R6 no pop without tick", rd_byte, 0);
    do_pop();
    chk(rd_byte == 8'h11, "R6 pop with tick", rd_byte, 8'h11);

    // R8 hold timing
    do_reset();
    settle();
    do_write(8'h33);
    repeat (3) @(negedge clk);
    chk(fifo_level == 2'b00, "R8 held without ticks", fifo_level, 0);
    bit_tick = 1'b1;
    @(negedge clk);
    chk(fifo_level == 2'b00, "R8 held after tick 1", fifo_level, 0);
    @(negedge clk);
    bit_tick = 1'b0;
    chk(fifo_level == 2'b00, "R8 held after tick 2", fifo_level, 0);
    @(negedge clk);
    chk(fifo_level == 2'b01, "R8 released", fifo_level, 1);

    // R9 simultaneous write and pop
    do_reset();
    for (int k = 0; k < DEPTH; k++) do_write(pat(70, k));
    wr_en = 1'b1; wr_byte = 8'hEE; rd_en = 1'b1; bit_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; bit_tick = 1'b0;
    chk(rd_byte == pat(70, 0), "R9 full pop proceeds", rd_byte, pat(70, 0));
    chk(overflow == 1'b1, "R9 full write dropped", overflow, 1);
    for (int k = 1; k < DEPTH; k++) begin
      do_pop();
      chk(rd_byte == pat(70, k), "R9 full drain", rd_byte, pat(70, k));
    end
    settle();
    chk(fifo_level == 2'b00, "R9 no extra byte", fifo_level, 0);

    do_reset();
    wr_en = 1'b1; wr_byte = 8'h77; rd_en = 1'b1; bit_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; bit_tick = 1'b0;
    chk(rd_byte == 8'h00, "R9 empty pop refused", rd_byte, 0);
    settle();
    chk(fifo_level == 2'b01, "R9 empty write stored", fifo_level, 1);
    do_pop();
    chk(rd_byte == 8'h77, "R9 stored byte", rd_byte, 8'h77);

    do_reset();
    do_write(8'h01); do_write(8'h02);
    wr_en = 1'b1; wr_byte = 8'h03; rd_en = 1'b1; bit_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; bit_tick = 1'b0;
    chk(rd_byte == 8'h01, "R9 mid pop", rd_byte, 1);
    for (int k = 2; k <= 3; k++) begin
      do_pop();
      chk(rd_byte == 8'(k), "R9 mid order", rd_byte, k);
    end
    settle();
    chk(fifo_level == 2'b00, "R9 mid count", fifo_level, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule